// File: doc/BRIEF.md
# Twenty-Pin GPIO Expander Register Core

This block holds the register file and pin-control logic of a 20-pin general-purpose I/O expander. A host-side byte port sets a start address with a strobe. It then moves a run of bytes through a pointer that advances on every access. Out-of-range start addresses fall back to register 0, and a burst that passes the last register continues at register 0.

The ten byte registers are as follows. Registers 0 to 2 hold pin data for pins 7:0, pins 15:8 and pins 19:16. Registers 3 to 5 hold per-pin interrupt masks in the same split. Registers 6 to 8 hold per-pin pull-up selects in the same split. Register 9 is a control register.

From these registers the block drives pin values and output enables, and it exports a pull-up enable vector. It passes the input pins through a synchronizer and keeps a sticky change flag for each pin. It combines the flags into one interrupt line whose active level is programmable. Reading any data register clears the flags.

Top module: `pinx_regbank`

## Requirements
- R1: When `start_valid` is high, the pointer loads `start_addr` if it is 9 or less, and loads 0 otherwise.
- R2: Each accepted write or read uses the register at the pointer and then advances the pointer by one. After register 9 the pointer goes to 0.
- R3: After a synchronous reset (`rst_n` low at a clock edge), the registers hold these values: data 00/00/00, masks FF/FF/0F, pull-ups 00/00/00 and control 07h.
- R4: Registers 2, 5, 8 and 9 hold four bits. A write drops data bits 7:4, and a read returns zeros in bits 7:4.
- R5: Control bits 0, 1 and 2 set the direction of pin groups 7:0, 15:8 and 19:16. A value of 1 makes the group an input, with `pin_oe` low for its pins. A value of 0 makes it an output, with `pin_oe` high. `pin_out` always carries the data register bits.
- R6: A read returns its byte on `rd_data` with `rd_valid` high in the cycle after `rd_req`. In a data register, input-mode bits return the synchronized pin level and output-mode bits return the stored value.
- R7: A pin's flag sets when its synchronized level changes while its mask bit is 0 and its group is an input. Masked pins (mask bit 1) and output pins never set a flag.
- R8: A read of register 0, 1 or 2 clears all flags. A change detected in the same cycle still sets its flag.
- R9: Control bit 3 sets the interrupt polarity. With the bit at 0, `irq` is low while any flag is set and high otherwise. With the bit at 1, the levels are reversed.
- R10: `pullup_en` equals the pull-up registers, with bit 0 of register 6 driving pin 0. The bits have no other effect.
- R11: A start strobe takes priority over a same-cycle write or read, which is then dropped. A write takes priority over a same-cycle read, which is then dropped and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start-address strobe |
| start_addr | input | 8 | Start address |
| wr_valid | input | 1 | Write the byte at the pointer |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read the byte at the pointer |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte is valid |
| pin_in | input | 20 | Pin levels, asynchronous |
| pin_out | output | 20 | Pin drive values |
| pin_oe | output | 20 | Pin output enables |
| pullup_en | output | 20 | Pull-up enables |
| irq | output | 1 | Interrupt line, polarity set by control bit 3 |

## Verification
The assertions assume the host raises at most one of `start_valid`, `wr_valid` and `rd_req` in each cycle when it expects that access to take effect. Where the bench raises two of them at once, it does so only on purpose, to exercise the priority rule. They also assume `pin_in` holds each level for several clocks, so the synchronizer sees every change. The bench changes pins only between host transactions and then waits several clocks before it samples `irq`. This stimulus keeps the flag checks clear of synchronizer latency.

// File: rtl/pinx_pkg.sv
// Shared constants for the expander register core.
// Assumes a fixed 20-pin, ten-register layout; offsets matter because
// the pointer wrap and flag clearing depend on them.
package pinx_pkg;
    localparam int PIN_W    = 20;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 10;
    localparam int PTR_W    = $clog2(NUM_REGS);
    localparam int GROUPS   = 3;

    localparam logic [PTR_W-1:0] A_DATA0 = PTR_W'(0);
    localparam logic [PTR_W-1:0] A_DATA2 = PTR_W'(2);
    localparam logic [PTR_W-1:0] A_LAST  = PTR_W'(NUM_REGS - 1);

    // Reset value of each register
    function automatic logic [BYTE_W-1:0] reset_value(input int idx);
        case (idx)
            3, 4:    reset_value = 8'hFF;
            5:       reset_value = 8'h0F;
            9:       reset_value = 8'h07;
            default: reset_value = 8'h00;
        endcase
    endfunction

    // Writable bit mask of each register (narrow registers keep four bits)
    function automatic logic [BYTE_W-1:0] keep_mask(input int idx);
        case (idx)
            2, 5, 8, 9: keep_mask = 8'h0F;
            default:    keep_mask = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/pinx_addr_ptr.sv
// Register pointer: loaded by the start strobe, advanced by each access.
// Assumes the caller resolves priority and raises step only for taken accesses.
module pinx_addr_ptr
    import pinx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr
);
    logic              in_range;
    logic [PTR_W-1:0]  ptr_q;

    // Out-of-range start addresses fall back to register zero
    always_comb in_range = (load_addr <= ADDR_W'(NUM_REGS - 1));

    // Pointer update: load, advance with wrap, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= A_DATA0;
        else if (load)
            ptr_q <= in_range ? PTR_W'(load_addr) : A_DATA0;
        else if (step)
            ptr_q <= (ptr_q == A_LAST) ? A_DATA0 : ptr_q + PTR_W'(1);
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/pinx_reg_file.sv
// Ten byte registers plus the read multiplexer and pin direction fan-out.
// Assumes pin_sync is already synchronized to clk.
module pinx_reg_file
    import pinx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [PIN_W-1:0]  data_vec,
    output logic [PIN_W-1:0]  mask_vec,
    output logic [PIN_W-1:0]  pup_vec,
    output logic [PIN_W-1:0]  in_mode,
    output logic              irq_pol
);
    logic [BYTE_W-1:0] reg_q [NUM_REGS];
    logic [GROUPS-1:0] dir_grp;
    logic [PIN_W-1:0]  view_vec;
    logic [23:0]       view_pad;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            // One register: reset value, masked write at its address
            always_ff @(posedge clk) begin
                if (!rst_n)
                    reg_q[g] <= reset_value(g);
                else if (wr_en && ptr == PTR_W'(g))
                    reg_q[g] <= wr_data & keep_mask(g);
            end
        end
    endgenerate

    // Unpack registers into per-pin vectors
    always_comb begin
        data_vec = {reg_q[2][3:0], reg_q[1], reg_q[0]};
        mask_vec = {reg_q[5][3:0], reg_q[4], reg_q[3]};
        pup_vec  = {reg_q[8][3:0], reg_q[7], reg_q[6]};
        dir_grp  = reg_q[9][2:0];
        irq_pol  = reg_q[9][3];
    end

    generate
        for (g = 0; g < PIN_W; g++) begin : g_dir
            assign in_mode[g] = dir_grp[g / 8];
        end
    endgenerate

    // Data view: pin level for inputs, stored value for outputs
    always_comb begin
        view_vec = (in_mode & pin_sync) | (~in_mode & data_vec);
        view_pad = {4'h0, view_vec};
    end

    // Read multiplexer
    always_comb begin
        if (ptr <= A_DATA2)
            rd_byte = view_pad[ptr*8 +: 8];
        else if (ptr <= A_LAST)
            rd_byte = reg_q[ptr];
        else
            rd_byte = 8'h00;
    end
endmodule

// File: rtl/pinx_irq_unit.sv
// Input synchronizer, per-pin change flags and the interrupt output.
// Assumes pin_in is asynchronous and holds each level for several clocks.
module pinx_irq_unit
    import pinx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_in,
    input  logic [PIN_W-1:0] mask_vec,
    input  logic [PIN_W-1:0] in_mode,
    input  logic             irq_pol,
    input  logic             clr,
    output logic [PIN_W-1:0] pin_sync,
    output logic [PIN_W-1:0] flags,
    output logic             irq
);
    logic [PIN_W-1:0] stage_q [SYNC_STAGES];
    logic [PIN_W-1:0] prev_q;
    logic [PIN_W-1:0] flag_q;
    logic [PIN_W-1:0] set_vec;

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign pin_sync = stage_q[SYNC_STAGES-1];

    // Change detection on enabled input pins
    always_comb set_vec = (pin_sync ^ prev_q) & ~mask_vec & in_mode;

    // Previous level and sticky flags; a new change wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= pin_sync;
            flag_q <= (clr ? '0 : flag_q) | set_vec;
        end
    end

    assign flags = flag_q;

    // Interrupt level follows the programmed polarity
    always_comb irq = irq_pol ? (|flag_q) : ~(|flag_q);
endmodule

// File: rtl/pinx_regbank.sv
// Top of the expander register core: host byte port, registers, pins, interrupt.
// Assumes a single clock; pin_in is asynchronous to it.
module pinx_regbank
    import pinx_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic              rd_req,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic [19:0]       pin_in,
    output logic [19:0]       pin_out,
    output logic [19:0]       pin_oe,
    output logic [19:0]       pullup_en,
    output logic              irq
);
    logic [PTR_W-1:0]  ptr_q;
    logic              take_wr, take_rd, step, clr_flags;
    logic [BYTE_W-1:0] rd_byte;
    logic [PIN_W-1:0]  data_vec, mask_vec, pup_vec, in_mode, pin_sync, flags;
    logic              irq_pol;
    logic [BYTE_W-1:0] rd_data_q;
    logic              rd_valid_q;

    // Access priority: start, then write, then read
    always_comb begin
        take_wr   = wr_valid & ~start_valid;
        take_rd   = rd_req & ~start_valid & ~wr_valid;
        step      = take_wr | take_rd;
        clr_flags = take_rd & (ptr_q <= A_DATA2);
    end

    pinx_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(start_valid), .load_addr(start_addr),
        .step(step), .ptr(ptr_q)
    );

    pinx_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(take_wr), .ptr(ptr_q), .wr_data(wr_data),
        .pin_sync(pin_sync), .rd_byte(rd_byte), .data_vec(data_vec),
        .mask_vec(mask_vec), .pup_vec(pup_vec), .in_mode(in_mode), .irq_pol(irq_pol)
    );

    pinx_irq_unit #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mask_vec(mask_vec),
        .in_mode(in_mode), .irq_pol(irq_pol), .clr(clr_flags),
        .pin_sync(pin_sync), .flags(flags), .irq(irq)
    );

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= take_rd;
            if (take_rd) rd_data_q <= rd_byte;
        end
    end

    assign rd_data   = rd_data_q;
    assign rd_valid  = rd_valid_q;
    assign pin_out   = data_vec;
    assign pin_oe    = ~in_mode;
    assign pullup_en = pup_vec;
endmodule

// File: rtl/pinx_regbank_chk.sv
// Assertion checker bound to the top; observes ports and internal state.
module pinx_regbank_chk
    import pinx_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_valid,
    input logic [ADDR_W-1:0] start_addr,
    input logic              wr_valid,
    input logic              rd_req,
    input logic [PTR_W-1:0]  ptr,
    input logic [7:0]        rd_data,
    input logic [PIN_W-1:0]  flags,
    input logic [PIN_W-1:0]  mask_vec
);
    // R1: pointer never leaves the register space
    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= A_LAST);

    // R1: out-of-range start address lands on register zero
    p_start_oob_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_addr > ADDR_W'(NUM_REGS - 1)) |=> ptr == A_DATA0);

    // R2: an access at the last register wraps to zero
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_valid && (wr_valid || rd_req) && ptr == A_LAST) |=> ptr == A_DATA0);

    // R4: narrow registers read back with a zero upper nibble
    p_narrow_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !start_valid && !wr_valid &&
         (ptr == PTR_W'(2) || ptr == PTR_W'(5) || ptr == PTR_W'(8) || ptr == A_LAST))
        |=> rd_data[7:4] == 4'h0);

    // R7: a masked pin never raises a new flag
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & $past(mask_vec)) == '0));
endmodule

bind pinx_regbank pinx_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .wr_valid(wr_valid), .rd_req(rd_req), .ptr(ptr_q), .rd_data(rd_data),
    .flags(flags), .mask_vec(mask_vec)
);

// File: tb/tb_pinx_regbank.sv
`timescale 1ns/1ps
module tb_pinx_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [7:0]  start_addr = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [19:0] pin_in = 20'h53CA5;
    logic [19:0] pin_out, pin_oe, pullup_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    pinx_regbank dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pullup_en(pullup_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drivers: called at a negedge, return at the next negedge
    task automatic set_ptr(input logic [7:0] a);
        start_valid = 1'b1; start_addr = a;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop expected bytes as reads return
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected read: actual %h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(2.5 * 2 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        // R3 reset state at the pins
        check("R3 pin_oe", pin_oe, 20'h00000);
        check("R3 pullup", pullup_en, 20'h00000);
        check("R9 irq idle low-active", {19'h0, irq}, 20'h1);
        // R3/R6 burst read of all registers, then R2 wrap
        set_ptr(8'h00);
        rd(8'hA5, "R6 data0 pins"); rd(8'h3C, "R6 data1 pins"); rd(8'h05, "R4 data2");
        rd(8'hFF, "R3 mask0"); rd(8'hFF, "R3 mask1"); rd(8'h0F, "R3 mask2");
        rd(8'h00, "R3 pup0"); rd(8'h00, "R3 pup1"); rd(8'h00, "R3 pup2");
        rd(8'h07, "R3 ctrl"); rd(8'hA5, "R2 wrap");
        // R1 out-of-range and in-range start
        set_ptr(8'hC3); rd(8'hA5, "R1 oob start");
        set_ptr(8'h09); rd(8'h07, "R1 start 9"); rd(8'hA5, "R2 wrap read");
        // R10/R4 pull-ups and narrow write
        set_ptr(8'h06); wr(8'h81); wr(8'h42); wr(8'hF6);
        idle(1);
        check("R10 pullup_en", pullup_en, 20'h64281);
        set_ptr(8'h08); rd(8'h06, "R4 narrow readback");
        // R5 direction and drive
        set_ptr(8'h00); wr(8'h5A); wr(8'h77); wr(8'hFE);
        set_ptr(8'h09); wr(8'h05);
        idle(1);
        check("R5 pin_oe", pin_oe, 20'h0FF00);
        check("R5 pin_out", pin_out, 20'hE775A);
        rd(8'hA5, "R6 input bits"); rd(8'h77, "R6 output bits"); rd(8'h05, "R6 input hi");
        // R7 masked change sets nothing
        pin_in = 20'h53CA4;
        idle(6);
        check("R7 masked no irq", {19'h0, irq}, 20'h1);
        set_ptr(8'h03); wr(8'h00);
        pin_in = 20'h53CA5;
        idle(6);
        check("R9 active-low asserted", {19'h0, irq}, 20'h0);
        set_ptr(8'h09); wr(8'h0D);
        idle(1);
        check("R9 active-high asserted", {19'h0, irq}, 20'h1);
        set_ptr(8'h00); rd(8'hA5, "R6 data0 after change");
        idle(1);
        check("R8 flags cleared", {19'h0, irq}, 20'h0);
        // R7 output pin change sets nothing
        set_ptr(8'h04); wr(8'h00);
        pin_in = 20'h53DA5;
        idle(6);
        check("R7 output pin quiet", {19'h0, irq}, 20'h0);
        // R11 start beats write, write beats read
        start_valid = 1'b1; start_addr = 8'h03; wr_valid = 1'b1; wr_data = 8'h11;
        @(negedge clk);
        start_valid = 1'b0; wr_valid = 1'b0;
        rd(8'h00, "R11 start over write");
        wr_valid = 1'b1; rd_req = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0;
        set_ptr(8'h04); rd(8'h3C, "R11 write over read");
        idle(4);
        check("R6 all reads returned", 20'(exp_q.size()), 20'h0);
        finish_run();
    end
endmodule